// File: doc/BRIEF.md
# PHY Status Register Aggregator

This block builds the 16-bit read-only status word that an Ethernet PHY exposes at management address 0x10. It brings live link-state levels together with sticky event flags in one place, so that management software can see the common state with a single read. Level inputs come straight from the link, auto-negotiation, 10/100 datapath and crossover logic. Event inputs are single-cycle pulses that set sticky flags.

Each sticky flag belongs to another register in the management space. The flag is cleared only when that register is read, which the block sees as a read strobe together with a 5-bit address. Reading the status word itself never clears anything. When a set pulse and a clearing read land in the same cycle, the set is kept. The speed and duplex fields are reported only when a valid link exists and auto-negotiation is either disabled or complete. Otherwise both fields read 0.

The status word is combinational from the held flags and the live levels. A read therefore returns the values held before any clear that the same read causes.

Top module: `phy_status_reg`

## Requirements
- R1: After reset, every sticky flag is 0, bit 15 of `status_word` is always 0, and with all live inputs low the whole word is 0x0000.
- R2: Live bits follow their inputs in the same cycle, at these positions: bit 14 `mdix_swapped` (1 = pairs swapped), bit 10 `sig_detect`, bit 9 `descr_lock`, bit 5 `jabber`, bit 4 `an_done`, bit 3 `loopback_on`, bit 0 `link_up`.
- R3: Bit 13, the receive-error flag, sets one cycle after an `rx_err_evt` pulse. It clears after a read of address 0x15.
- R4: Bit 11, the false-carrier flag, sets after a `false_carrier_evt` pulse. It clears after a read of address 0x14.
- R5: Bit 12, the inverted-polarity flag, sets after a `pol_inv_evt` pulse. It clears after a read of the 10BASE-T status address, which is parameter `A_POL10` (default 0x1A).
- R6: Bit 8, the page-received flag, sets after a `page_rx_evt` pulse. It clears after a read of address 0x06.
- R7: Bit 6, the remote-fault flag, sets after a `remote_fault_evt` pulse. It clears after a read of address 0x01 or on reset.
- R8: Bit 7, the interrupt-pending flag, sets after an `irq_evt` pulse. It clears after a read of address 0x12.
- R9: A read of 0x10, or of any address not named in R3 to R8, leaves every sticky flag unchanged.
- R10: A set pulse in the same cycle as the clearing read of the same flag leaves that flag at 1.
- R11: During the cycle of a clearing read, `status_word` still shows the flag as 1. The flag reads 0 from the following cycle.
- R12: Bit 1 (`speed_10`, 1 = 10 Mb/s) and bit 2 (`full_duplex`, 1 = full duplex) are passed through only when `link_up` = 1 and (`an_enable` = 0 or `an_done` = 1). Otherwise both bits read 0.
- R13: While `mgmt_rd` = 0, the value on `mgmt_addr` clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdix_swapped | input | 1 | Crossover engine reports pairs swapped |
| sig_detect | input | 1 | 100BASE-TX signal detect |
| descr_lock | input | 1 | 100BASE-TX descrambler locked |
| jabber | input | 1 | Jabber condition level |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_done | input | 1 | Auto-negotiation complete |
| loopback_on | input | 1 | Loopback enabled |
| full_duplex | input | 1 | Resolved duplex, before validity gating |
| speed_10 | input | 1 | Resolved speed (1 = 10 Mb/s), before gating |
| link_up | input | 1 | Valid link |
| rx_err_evt | input | 1 | Receive error pulse |
| false_carrier_evt | input | 1 | False carrier pulse |
| pol_inv_evt | input | 1 | Inverted polarity detected pulse |
| page_rx_evt | input | 1 | Link code word page received pulse |
| remote_fault_evt | input | 1 | Partner remote fault pulse |
| irq_evt | input | 1 | Internal interrupt source pulse |
| mgmt_rd | input | 1 | Management read strobe |
| mgmt_addr | input | 5 | Address of the register being read |
| status_word | output | 16 | Assembled status word |

## Verification
A flag stuck at 1 shows up one cycle after its clearing read, because the bit in `status_word` stays high. A flag that drops too early shows up during the read cycle itself. A wrong address decode shows up as the wrong bit clearing, or no bit clearing, in the cycle after any read. The bench sweeps all 32 addresses against all six flags to expose this. A gating fault in speed or duplex is visible in the same cycle. The bench covers it by sweeping all 32 combinations of link, negotiation and resolved-mode inputs.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  // sticky flag indices
  localparam int SK_RXERR = 0;
  localparam int SK_FCS   = 1;
  localparam int SK_POL   = 2;
  localparam int SK_PAGE  = 3;
  localparam int SK_RFLT  = 4;
  localparam int SK_IRQ   = 5;
  localparam int NSTICKY  = 6;
  localparam int WORD_W   = 16;
endpackage

// File: rtl/phy_stat_clr_dec.sv
module phy_stat_clr_dec #(
  parameter int ADDR_W = 5,
  parameter int N      = 6,
  parameter logic [N*ADDR_W-1:0] ADDRS = '0
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N-1:0]      clr_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign clr_o[i] = rd_i && (addr_i == ADDRS[i*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/phy_stat_latch.sv
module phy_stat_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;
  logic [N-1:0] upd_en;

  always_comb begin
    upd_en = set_i | clr_i;
    q_nxt  = set_i | (q_r & ~clr_i);
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r[i] <= 1'b0;
      end else if (upd_en[i]) begin
        q_r[i] <= q_nxt[i];
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_r[i]); // R10
    AST_CLR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_r[i]); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> (q_r[i] == $past(q_r[i]))); // R9
  end

  assign q_o = q_r;
endmodule

// File: rtl/phy_stat_gate.sv
module phy_stat_gate (
  input  logic link_i,
  input  logic an_en_i,
  input  logic an_done_i,
  input  logic dup_i,
  input  logic spd_i,
  output logic dup_o,
  output logic spd_o
);
  logic valid;
  always_comb begin
    valid = link_i && (!an_en_i || an_done_i);
    dup_o = valid & dup_i;
    spd_o = valid & spd_i;
  end
endmodule

// File: rtl/phy_status_reg.sv
module phy_status_reg
  import phy_stat_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [4:0]  A_SELF  = 5'h10,
  parameter logic [4:0]  A_BSTAT = 5'h01,
  parameter logic [4:0]  A_ANEXP = 5'h06,
  parameter logic [4:0]  A_ISTAT = 5'h12,
  parameter logic [4:0]  A_FCS   = 5'h14,
  parameter logic [4:0]  A_RXERR = 5'h15,
  parameter logic [4:0]  A_POL10 = 5'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdix_swapped,
  input  logic              sig_detect,
  input  logic              descr_lock,
  input  logic              jabber,
  input  logic              an_enable,
  input  logic              an_done,
  input  logic              loopback_on,
  input  logic              full_duplex,
  input  logic              speed_10,
  input  logic              link_up,
  input  logic              rx_err_evt,
  input  logic              false_carrier_evt,
  input  logic              pol_inv_evt,
  input  logic              page_rx_evt,
  input  logic              remote_fault_evt,
  input  logic              irq_evt,
  input  logic              mgmt_rd,
  input  logic [ADDR_W-1:0] mgmt_addr,
  output logic [WORD_W-1:0] status_word
);
  localparam logic [NSTICKY*ADDR_W-1:0] CLR_ADDRS =
    {A_ISTAT, A_BSTAT, A_ANEXP, A_POL10, A_FCS, A_RXERR};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSTICKY-1:0] sk_set;
  logic [NSTICKY-1:0] sk_clr;
  logic [NSTICKY-1:0] sk_q;
  logic               dup_g;
  logic               spd_g;

  always_comb begin
    sk_set           = '0;
    sk_set[SK_RXERR] = rx_err_evt;
    sk_set[SK_FCS]   = false_carrier_evt;
    sk_set[SK_POL]   = pol_inv_evt;
    sk_set[SK_PAGE]  = page_rx_evt;
    sk_set[SK_RFLT]  = remote_fault_evt;
    sk_set[SK_IRQ]   = irq_evt;
  end

  phy_stat_clr_dec #(
    .ADDR_W (ADDR_W),
    .N      (NSTICKY),
    .ADDRS  (CLR_ADDRS)
  ) u_clr_dec (
    .rd_i   (mgmt_rd),
    .addr_i (mgmt_addr),
    .clr_o  (sk_clr)
  );

  phy_stat_latch #(
    .N (NSTICKY)
  ) u_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (sk_set),
    .clr_i (sk_clr),
    .q_o   (sk_q)
  );

  phy_stat_gate u_gate (
    .link_i    (link_up),
    .an_en_i   (an_enable),
    .an_done_i (an_done),
    .dup_i     (full_duplex),
    .spd_i     (speed_10),
    .dup_o     (dup_g),
    .spd_o     (spd_g)
  );

  always_comb begin
    status_word     = '0;
    status_word[14] = mdix_swapped;
    status_word[13] = sk_q[SK_RXERR];
    status_word[12] = sk_q[SK_POL];
    status_word[11] = sk_q[SK_FCS];
    status_word[10] = sig_detect;
    status_word[9]  = descr_lock;
    status_word[8]  = sk_q[SK_PAGE];
    status_word[7]  = sk_q[SK_IRQ];
    status_word[6]  = sk_q[SK_RFLT];
    status_word[5]  = jabber;
    status_word[4]  = an_done;
    status_word[3]  = loopback_on;
    status_word[2]  = dup_g;
    status_word[1]  = spd_g;
    status_word[0]  = link_up;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    status_word[15] == 1'b0); // R1
  AST_GATE_NOLINK: assert property (@(posedge clk) disable iff (!rst_int_n)
    !link_up |-> (status_word[2:1] == 2'b00)); // R12
  AST_GATE_ANBUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (an_enable && !an_done) |-> (status_word[2:1] == 2'b00)); // R12
  AST_SELF_NOCLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mgmt_rd && mgmt_addr == A_SELF) |=>
      ((status_word[13:11] & ~$past(status_word[13:11])) == 3'b000 ||
       $past(sk_set) != '0) &&
      ((status_word[13:11] | ~$past(status_word[13:11])) == 3'b111)); // R9
  AST_NORD_NOCLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mgmt_rd |=> ((sk_q | ~$past(sk_q)) == '1)); // R13
endmodule

// File: tb/phy_status_reg_tb.sv
module phy_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdix_swapped = 0, sig_detect = 0, descr_lock = 0, jabber = 0;
  logic an_enable = 0, an_done = 0, loopback_on = 0, full_duplex = 0;
  logic speed_10 = 0, link_up = 0;
  logic [5:0] ev = '0;  // 0 rxerr,1 fcs,2 pol,3 page,4 rflt,5 irq
  logic mgmt_rd = 0;
  logic [4:0] mgmt_addr = '0;
  logic [15:0] status_word;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam int POS [6] = '{13, 11, 12, 8, 6, 7};
  localparam logic [4:0] CADDR [6] = '{5'h15, 5'h14, 5'h1A, 5'h06, 5'h01, 5'h12};

  always #5 clk = ~clk;

  phy_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .mdix_swapped(mdix_swapped), .sig_detect(sig_detect),
    .descr_lock(descr_lock), .jabber(jabber), .an_enable(an_enable),
    .an_done(an_done), .loopback_on(loopback_on),
    .full_duplex(full_duplex), .speed_10(speed_10), .link_up(link_up),
    .rx_err_evt(ev[0]), .false_carrier_evt(ev[1]), .pol_inv_evt(ev[2]),
    .page_rx_evt(ev[3]), .remote_fault_evt(ev[4]), .irq_evt(ev[5]),
    .mgmt_rd(mgmt_rd), .mgmt_addr(mgmt_addr), .status_word(status_word)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [5:0] m);
    logic [15:0] w = '0;
    for (int i = 0; i < 6; i++) if (m[i]) w[POS[i]] = 1'b1;
    return w;
  endfunction

  function automatic logic [5:0] clr_of(input logic [4:0] a);
    logic [5:0] c = '0;
    for (int i = 0; i < 6; i++) if (CADDR[i] == a) c[i] = 1'b1;
    return c;
  endfunction

  task automatic set_all();
    @(negedge clk); ev = 6'h3F;
    @(negedge clk); ev = '0;
  endtask

  task automatic read_addr(input logic [4:0] a, input logic [15:0] exp_during, input string req);
    @(negedge clk); mgmt_rd = 1'b1; mgmt_addr = a;
    #1 chk(status_word, exp_during, req);
    @(negedge clk); mgmt_rd = 1'b0; mgmt_addr = '0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); mgmt_rd = 1'b1; mgmt_addr = CADDR[i];
    end
    @(negedge clk); mgmt_rd = 1'b0; mgmt_addr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(status_word, 16'h0000, "R1 reset");

    // R2 live bits, all 128 combinations
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      {mdix_swapped, sig_detect, descr_lock, jabber, an_done, loopback_on, link_up} = 7'(v);
      #1 chk(status_word & 16'h4639,
             {1'b0, v[6], 3'b0, v[5], v[4], 3'b0, v[3], v[2], v[1], 2'b0, v[0]}, "R2 live");
    end
    @(negedge clk);
    {mdix_swapped, sig_detect, descr_lock, jabber, an_done, loopback_on, link_up} = '0;

    // R12 gating sweep
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {link_up, an_enable, an_done, full_duplex, speed_10} = 5'(v);
      #1 begin
        logic ok;
        ok = v[4] && (!v[3] || v[2]);
        chk({13'b0, status_word[2:1], 1'b0}, {13'b0, ok & v[1], ok & v[0], 1'b0}, "R12 gate");
      end
    end
    @(negedge clk);
    {link_up, an_enable, an_done, full_duplex, speed_10} = '0;

    // R3-R9, R11: every address against every flag
    for (int a = 0; a < 32; a++) begin
      set_all();
      chk(status_word, 16'h39C0, "R3-R8 set");
      read_addr(5'(a), 16'h39C0, "R11 pre-clear read");
      chk(status_word, word_of(~clr_of(5'(a))),
          (a == 16) ? "R9 self read" : "R3 R4 R5 R6 R7 R8 R9 decode");
      clear_all();
    end

    // R13 strobe low
    set_all();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); mgmt_rd = 1'b0; mgmt_addr = CADDR[i];
    end
    @(negedge clk);
    chk(status_word, 16'h39C0, "R13 no strobe");
    clear_all();
    chk(status_word, 16'h0000, "R3 R8 clear all");

    // R10 set wins over same-cycle clear
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ev = 6'(1 << i); mgmt_rd = 1'b1; mgmt_addr = CADDR[i];
      @(negedge clk); ev = '0; mgmt_rd = 1'b0;
      chk(status_word, word_of(6'(1 << i)), "R10 set wins");
      read_addr(CADDR[i], word_of(6'(1 << i)), "R11 pre-clear");
      chk(status_word, 16'h0000, "R11 cleared");
    end

    // R7 reset clears remote fault
    @(negedge clk); ev[4] = 1'b1;
    @(negedge clk); ev = '0;
    rst_n = 1'b0;
    #1 chk(status_word, 16'h0000, "R7 reset clears");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule